// File: doc/BRIEF.md
# Ethernet Receive Frame Status Classifier

This block sits on a 4-bit media-independent receive stream and produces one 10-bit status word for each accepted frame. Each nibble is sampled on the system clock only when a nibble-enable input is high. The block finds the start-of-frame delimiter and rebuilds bytes from nibble pairs, low nibble first. As the bytes arrive it decodes the destination address, the Type/Length field, a single VLAN tag and, for MAC control frames, the opcode. When the frame ends it presents the status word together with a one-cycle strobe.

Some conditions seen on the line between frames are not reported at once. A carrier event, or a data-valid burst too short to form a frame, is held in a sticky flag and reported in the status of the next frame that is delivered. Receive-buffer pressure is signalled on a full input. A frame that starts while that input is high is reported with the overrun bit alone. From then on every frame is dropped silently until software pulses a clear input.

Top module: `rx_frame_classifier`

## Requirements
- R1: For each accepted frame, status_vld_o is high for exactly one clock. That clock follows the edge that samples the first enabled nibble with rx_dv_i low after the delimiter. status_o keeps its value until the next strobe.
- R2: Destination bytes 0..5 are the first six bytes after the delimiter. Bit 8 is set when all 48 bits are one. Bit 9 is set when bit 0 of byte 0 is one and the address is not all ones.
- R3: Bit 7 is set when bytes 12..13 (high byte first) hold 0x8100. The effective Type/Length then moves to bytes 16..17.
- R4: A value of 0x0600 or more in the effective Type/Length is a type. If that type is 0x8808, bit 6 is set when the 16-bit opcode in the two bytes after it is not 0x0001.
- R5: A value below 0x0600 is a length. Bit 5 is set when the length exceeds 1518. Bit 4 is set when the length differs from the byte count minus the header (14 bytes, or 18 with a tag) minus 4 trailing FCS bytes.
- R6: Bit 3 is set when rx_er_i is high on any enabled nibble with rx_dv_i high in the current burst.
- R7: An enabled nibble with rx_dv_i=0, rx_er_i=1 and rxd_i=4'hE latches a carrier flag. The flag appears as bit 2 of the next normal status and is cleared by it.
- R8: A burst counts as a short event if rx_dv_i falls before the delimiter, or if fewer than 64 bytes follow the delimiter. A short event gives no strobe, latches a flag that appears as bit 1 of the next normal status, and is cleared by that status.
- R9: A frame whose delimiter arrives while buf_full_i is high and the overrun flag is clear sets ovr_flag_o. Its status is 10'h001, and the sticky flags are left intact.
- R10: While ovr_flag_o is high, frames produce no strobe and short events are not recorded. The flag stays high until an ovr_clr_i pulse clears it.
- R11: After reset, status_o, status_vld_o and ovr_flag_o are zero and both sticky flags are clear.
- R12: The delimiter is the first nibble 4'hD in a burst. Bytes are formed low nibble first. Cycles with nib_en_i low have no effect, whatever the stream inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nib_en_i | input | 1 | Nibble sample enable |
| rxd_i | input | 4 | Receive data nibble |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error |
| buf_full_i | input | 1 | All receive buffers occupied |
| ovr_clr_i | input | 1 | Software clear of the overrun flag |
| status_o | output | 10 | Frame status word, bit 9 down to bit 0 as in R2..R9 |
| status_vld_o | output | 1 | One-cycle status strobe |
| ovr_flag_o | output | 1 | Overrun flag, drop-all mode active |

## Verification
The hardest case to reach is a sticky flag that survives an overrun. The carrier flag must stay set through the frame that reports only the overrun, and through the silent-drop period after it. A short burst sent during that period must leave nothing behind once software clears the flag. The stimulus builds this in order: it latches a carrier event, raises buf_full_i for one frame, drops a full frame and a short burst, pulses the clear input, and then sends a clean frame. That last frame must report the carrier bit and must not report the short-event bit.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA
  } rx_state_e;

  typedef struct packed {
    logic mcast;
    logic bcast;
    logic vlan;
    logic bad_op;
    logic len_oor;
    logic len_mis;
    logic code_err;
    logic carrier;
    logic short_ev;
    logic overrun;
  } rx_status_t;

  localparam logic [3:0]  SFD_NIB    = 4'hD;
  localparam logic [3:0]  CAR_NIB    = 4'hE;
  localparam logic [15:0] TYPE_MIN   = 16'h0600;
  localparam logic [15:0] ETH_VLAN   = 16'h8100;
  localparam logic [15:0] ETH_MACCTL = 16'h8808;
  localparam logic [15:0] OP_PAUSE   = 16'h0001;
  localparam int          TL_IDX     = 12;
  localparam int          TAG_BYTES  = 4;

endpackage

// File: rtl/rx_nibble_assembler.sv
module rx_nibble_assembler
  import rx_status_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nib_en_i,
  input  logic [3:0]       rxd_i,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             pre_abort_o,
  output logic             code_err_o
);

  rx_state_e        state_q;
  logic [3:0]       lo_q;
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cv_q;
  logic             act;

  assign act         = nib_en_i & rx_dv_i;
  assign sof_o       = act & (state_q != ST_DATA) & (rxd_i == SFD_NIB);
  assign eof_o       = nib_en_i & ~rx_dv_i & (state_q == ST_DATA);
  assign pre_abort_o = nib_en_i & ~rx_dv_i & (state_q == ST_PRE);
  assign byte_vld_o  = act & (state_q == ST_DATA) & phase_q;
  assign byte_o      = {rxd_i, lo_q};
  assign byte_idx_o  = cnt_q;
  assign code_err_o  = cv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lo_q    <= '0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      cv_q    <= 1'b0;
    end else if (nib_en_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (rx_dv_i) begin
            state_q <= sof_o ? ST_DATA : ST_PRE;
            cv_q    <= rx_er_i;
            phase_q <= 1'b0;
            cnt_q   <= '0;
          end
        end
        ST_PRE: begin
          if (!rx_dv_i) begin
            state_q <= ST_IDLE;
          end else begin
            cv_q <= cv_q | rx_er_i;
            if (sof_o) begin
              state_q <= ST_DATA;
              phase_q <= 1'b0;
              cnt_q   <= '0;
            end
          end
        end
        ST_DATA: begin
          if (!rx_dv_i) begin
            state_q <= ST_IDLE;
          end else begin
            cv_q    <= cv_q | rx_er_i;
            phase_q <= ~phase_q;
            if (!phase_q) lo_q <= rxd_i;
            else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SOF_FRESH_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> (cnt_q == '0) && !phase_q);  // R12

endmodule

// File: rtl/rx_header_parser.sv
module rx_header_parser
  import rx_status_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic             grp_o,
  output logic             bcast_o,
  output logic             vlan_o,
  output logic [15:0]      tl_o,
  output logic [15:0]      op_o,
  output logic [CNT_W-1:0] hdr_len_o
);

  localparam int DA_BYTES = 6;

  logic             grp_q, bc_q, vlan_q;
  logic [7:0]       tl_hi_q, op_hi_q;
  logic [15:0]      tl_q, op_q;
  logic [CNT_W-1:0] tl_idx;
  logic [15:0]      tl_new;

  assign tl_idx    = vlan_q ? CNT_W'(TL_IDX + TAG_BYTES) : CNT_W'(TL_IDX);
  assign tl_new    = {tl_hi_q, byte_i};
  assign hdr_len_o = tl_idx + CNT_W'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q   <= 1'b0;
      bc_q    <= 1'b0;
      vlan_q  <= 1'b0;
      tl_hi_q <= '0;
      op_hi_q <= '0;
      tl_q    <= '0;
      op_q    <= '0;
    end else if (sof_i) begin
      grp_q   <= 1'b0;
      bc_q    <= 1'b0;
      vlan_q  <= 1'b0;
      tl_q    <= '0;
      op_q    <= '0;
    end else if (byte_vld_i) begin
      if (idx_i == '0) begin
        grp_q <= byte_i[0];
        bc_q  <= &byte_i;
      end else if (idx_i < CNT_W'(DA_BYTES)) begin
        bc_q  <= bc_q & (&byte_i);
      end
      if (idx_i == tl_idx) tl_hi_q <= byte_i;
      if (idx_i == tl_idx + CNT_W'(1)) begin
        tl_q <= tl_new;
        if (!vlan_q && tl_new == ETH_VLAN) vlan_q <= 1'b1;
      end
      if (idx_i == tl_idx + CNT_W'(2)) op_hi_q <= byte_i;
      if (idx_i == tl_idx + CNT_W'(3)) op_q    <= {op_hi_q, byte_i};
    end
  end

  assign grp_o   = grp_q;
  assign bcast_o = bc_q;
  assign vlan_o  = vlan_q;
  assign tl_o    = tl_q;
  assign op_o    = op_q;

  AST_VLAN_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlan_q && !sof_i |=> vlan_q);  // R3

endmodule

// File: rtl/rx_event_tracker.sv
module rx_event_tracker
  import rx_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nib_en_i,
  input  logic [3:0] rxd_i,
  input  logic       rx_dv_i,
  input  logic       rx_er_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       pre_abort_i,
  input  logic       frame_short_i,
  input  logic       buf_full_i,
  input  logic       ovr_clr_i,
  output logic       carrier_o,
  output logic       short_o,
  output logic       ovr_flag_o,
  output logic       emit_norm_o,
  output logic       emit_ovr_o
);

  logic car_q, short_q, ovr_q, hit_q, drop_q;
  logic car_set, short_set, live_end;

  assign car_set     = nib_en_i & ~rx_dv_i & rx_er_i & (rxd_i == CAR_NIB);
  assign live_end    = eof_i & ~hit_q & ~drop_q;
  assign emit_ovr_o  = eof_i & hit_q;
  assign emit_norm_o = live_end & ~frame_short_i;
  // short events are dropped together with frames while overrun holds
  assign short_set   = ~ovr_q & (pre_abort_i | (live_end & frame_short_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q   <= 1'b0;
      short_q <= 1'b0;
      ovr_q   <= 1'b0;
      hit_q   <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      if (car_set)          car_q <= 1'b1;
      else if (emit_norm_o) car_q <= 1'b0;

      if (short_set)        short_q <= 1'b1;
      else if (emit_norm_o) short_q <= 1'b0;

      if (sof_i) begin
        hit_q  <= buf_full_i & ~ovr_q;
        drop_q <= ovr_q;
      end else if (eof_i) begin
        hit_q  <= 1'b0;
        drop_q <= 1'b0;
      end

      if (sof_i && buf_full_i) ovr_q <= 1'b1;
      else if (ovr_clr_i)      ovr_q <= 1'b0;
    end
  end

  assign carrier_o  = car_q;
  assign short_o    = short_q;
  assign ovr_flag_o = ovr_q;

  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !ovr_clr_i |=> ovr_q);  // R10
  AST_CAR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car_q && !emit_norm_o |=> car_q);  // R7
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> !emit_norm_o && !emit_ovr_o);  // R10

endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_status_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int MIN_FRAME = 64,
  parameter int MAX_LEN   = 1518,
  parameter int FCS_BYTES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       nib_en_i,
  input  logic [3:0] rxd_i,
  input  logic       rx_dv_i,
  input  logic       rx_er_i,
  input  logic       buf_full_i,
  input  logic       ovr_clr_i,
  output logic [9:0] status_o,
  output logic       status_vld_o,
  output logic       ovr_flag_o
);

  logic             byte_vld, sof, eof, pre_abort, code_err;
  logic [7:0]       byte_d;
  logic [CNT_W-1:0] byte_idx, hdr_len, need, data_len;
  logic             grp, bcast, vlan;
  logic [15:0]      tl, op;
  logic             carrier, short_ev, emit_norm, emit_ovr, frame_short;
  logic             is_type;
  rx_status_t       stat_d, stat_q;
  logic             vld_q;

  rx_nibble_assembler #(.CNT_W(CNT_W)) i_asm (
    .clk_i, .rst_ni, .nib_en_i, .rxd_i, .rx_dv_i, .rx_er_i,
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d),
    .byte_idx_o (byte_idx),
    .sof_o      (sof),
    .eof_o      (eof),
    .pre_abort_o(pre_abort),
    .code_err_o (code_err)
  );

  rx_header_parser #(.CNT_W(CNT_W)) i_hdr (
    .clk_i, .rst_ni,
    .sof_i     (sof),
    .byte_vld_i(byte_vld),
    .byte_i    (byte_d),
    .idx_i     (byte_idx),
    .grp_o     (grp),
    .bcast_o   (bcast),
    .vlan_o    (vlan),
    .tl_o      (tl),
    .op_o      (op),
    .hdr_len_o (hdr_len)
  );

  rx_event_tracker i_evt (
    .clk_i, .rst_ni, .nib_en_i, .rxd_i, .rx_dv_i, .rx_er_i,
    .sof_i        (sof),
    .eof_i        (eof),
    .pre_abort_i  (pre_abort),
    .frame_short_i(frame_short),
    .buf_full_i,
    .ovr_clr_i,
    .carrier_o    (carrier),
    .short_o      (short_ev),
    .ovr_flag_o,
    .emit_norm_o  (emit_norm),
    .emit_ovr_o   (emit_ovr)
  );

  assign frame_short = byte_idx < CNT_W'(MIN_FRAME);
  assign need        = hdr_len + CNT_W'(FCS_BYTES);
  assign data_len    = (byte_idx >= need) ? byte_idx - need : '0;
  assign is_type     = tl >= TYPE_MIN;

  always_comb begin
    stat_d          = '0;
    stat_d.bcast    = bcast;
    stat_d.mcast    = grp & ~bcast;
    stat_d.vlan     = vlan;
    stat_d.bad_op   = is_type & (tl == ETH_MACCTL) & (op != OP_PAUSE);
    stat_d.len_oor  = ~is_type & (tl > 16'(MAX_LEN));
    stat_d.len_mis  = ~is_type & (tl != 16'(data_len));
    stat_d.code_err = code_err;
    stat_d.carrier  = carrier;
    stat_d.short_ev = short_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= emit_norm | emit_ovr;
      if (emit_ovr) begin
        stat_q         <= '0;
        stat_q.overrun <= 1'b1;
      end else if (emit_norm) begin
        stat_q <= stat_d;
      end
    end
  end

  assign status_o     = stat_q;
  assign status_vld_o = vld_q;

  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |=> !status_vld_o);  // R1
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_vld_o |-> $stable(status_o));  // R1
  AST_BC_MC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o |-> !(status_o[9] && status_o[8]));  // R2
  AST_OVR_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o && status_o[0] |-> status_o[9:1] == '0);  // R9
  AST_TYPE_LEN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_vld_o && status_o[6] |-> !status_o[5] && !status_o[4]);  // R5

endmodule

// File: tb/test_rx_frame_classifier.sv
module test_rx_frame_classifier;

  typedef struct packed {
    logic [47:0] dst;
    logic        vlan;
    logic [15:0] tl;
    logic [15:0] op;
    logic [11:0] len;
    logic [9:0]  exp;
  } vec_t;

  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] PC = 48'h0180_C200_0001;
  localparam logic [47:0] UC = 48'h0200_0000_0001;
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{BC, 1'b0, 16'h0800, 16'h0000, 12'd64, 10'h100},  // R2 bcast
    '{MC, 1'b0, 16'h002E, 16'h0000, 12'd64, 10'h200},  // R2 mcast, R5 match
    '{UC, 1'b0, 16'h002E, 16'h0000, 12'd70, 10'h010},  // R5 mismatch
    '{UC, 1'b1, 16'h002A, 16'h0000, 12'd64, 10'h080},  // R3 tag, match
    '{PC, 1'b0, 16'h8808, 16'h0001, 12'd64, 10'h200},  // R4 pause ok
    '{PC, 1'b0, 16'h8808, 16'h0002, 12'd64, 10'h240},  // R4 bad op
    '{UC, 1'b0, 16'h05F0, 16'h0000, 12'd64, 10'h030},  // R5 oor
    '{UC, 1'b0, 16'h05EE, 16'h0000, 12'd64, 10'h010},  // R5 1518 edge
    '{UC, 1'b1, 16'h8808, 16'h0003, 12'd64, 10'h0C0},  // R3 R4
    '{UC, 1'b0, 16'h0600, 16'h0000, 12'd64, 10'h000},  // R4 type edge
    '{UC, 1'b0, 16'h05FF, 16'h0000, 12'd64, 10'h030}   // R5 top length
  };
  localparam vec_t PLAIN = '{UC, 1'b0, 16'h0800, 16'h0000, 12'd64, 10'h000};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nib_en = 1'b0;
  logic [3:0] rxd = '0;
  logic       rx_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic       buf_full = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [9:0] status;
  logic       status_vld;
  logic       ovr_flag;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] fb [0:2047];

  always #4 clk = ~clk;

  rx_frame_classifier i_rx_frame_classifier (
    .clk_i(clk), .rst_ni, .nib_en_i(nib_en), .rxd_i(rxd), .rx_dv_i(rx_dv),
    .rx_er_i(rx_er), .buf_full_i(buf_full), .ovr_clr_i(ovr_clr),
    .status_o(status), .status_vld_o(status_vld), .ovr_flag_o(ovr_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_nib(input logic [3:0] d, input logic dv, input logic er, input int gap);
    for (int g = 0; g < gap; g++) begin
      nib_en = 1'b0; rxd = 4'hE; rx_dv = 1'b0; rx_er = 1'b1;
      @(negedge clk);
    end
    nib_en = 1'b1; rxd = d; rx_dv = dv; rx_er = er;
    @(negedge clk);
    nib_en = 1'b0; rx_er = 1'b0;
  endtask

  task automatic build(input vec_t v);
    int p;
    for (int k = 0; k < 6; k++) fb[k] = v.dst[47-8*k -: 8];
    for (int k = 6; k < 12; k++) fb[k] = 8'h20 + 8'(k);
    p = 12;
    if (v.vlan) begin
      fb[12] = 8'h81; fb[13] = 8'h00; fb[14] = 8'h00; fb[15] = 8'h05;
      p = 16;
    end
    fb[p] = v.tl[15:8]; fb[p+1] = v.tl[7:0];
    fb[p+2] = v.op[15:8]; fb[p+3] = v.op[7:0];
    for (int k = p + 4; k < 2048; k++) fb[k] = 8'h3C;
  endtask

  task automatic send_frame(input int n, input int gap, input int er_byte);
    for (int k = 0; k < 15; k++) send_nib(4'h5, 1'b1, 1'b0, gap);
    send_nib(4'hD, 1'b1, 1'b0, gap);
    for (int k = 0; k < n; k++) begin
      send_nib(fb[k][3:0], 1'b1, k == er_byte, gap);
      send_nib(fb[k][7:4], 1'b1, 1'b0, gap);
    end
    send_nib(4'h0, 1'b0, 1'b0, gap);
    rx_dv = 1'b0; rxd = 4'h0;
  endtask

  task automatic expect_status(input string tag, input logic [9:0] exp);
    chk(tag, int'(status_vld), 1);
    chk(tag, int'(status), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1: watchdog expired, got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 status", int'(status), 0);
    chk("R11 vld", int'(status_vld), 0);
    chk("R11 ovr", int'(ovr_flag), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      build(VECS[i]);
      send_frame(int'(VECS[i].len), 0, -1);
      expect_status($sformatf("R2-table vector %0d", i), VECS[i].exp);
      @(negedge clk);
    end

    // R1: strobe lasts one cycle and status holds
    build(VECS[0]);
    send_frame(64, 0, -1);
    expect_status("R1 strobe", 10'h100);
    @(negedge clk);
    chk("R1 pulse width", int'(status_vld), 0);
    chk("R1 hold", int'(status), 'h100);

    // R12: junk on disabled cycles inside the frame
    build(VECS[1]);
    send_frame(64, 2, -1);
    expect_status("R12 gaps", 10'h200);
    @(negedge clk);

    // R6: error during data
    build(PLAIN);
    send_frame(64, 0, 20);
    expect_status("R6 code violation", 10'h008);
    @(negedge clk);

    // R7: carrier event reported once, non-matching errors ignored
    send_nib(4'h3, 1'b0, 1'b1, 0);
    send_nib(4'hE, 1'b0, 1'b0, 0);
    send_nib(4'hE, 1'b0, 1'b1, 0);
    build(PLAIN);
    send_frame(64, 0, -1);
    expect_status("R7 carrier", 10'h004);
    @(negedge clk);
    send_frame(64, 0, -1);
    expect_status("R7 cleared", 10'h000);
    @(negedge clk);

    // R8: short frame, then preamble-only burst
    send_frame(40, 0, -1);
    chk("R8 short no strobe", int'(status_vld), 0);
    @(negedge clk);
    send_frame(64, 0, -1);
    expect_status("R8 short flag", 10'h002);
    @(negedge clk);
    for (int k = 0; k < 6; k++) send_nib(4'h5, 1'b1, 1'b0, 0);
    send_nib(4'h0, 1'b0, 1'b0, 0);
    rx_dv = 1'b0;
    chk("R8 preamble abort no strobe", int'(status_vld), 0);
    @(negedge clk);
    send_frame(63, 0, -1);
    chk("R8 63 bytes no strobe", int'(status_vld), 0);
    @(negedge clk);
    send_frame(64, 0, -1);
    expect_status("R8 reported", 10'h002);
    @(negedge clk);

    // R9/R10: overrun with a pending carrier flag
    send_nib(4'hE, 1'b0, 1'b1, 0);
    buf_full = 1'b1;
    send_frame(64, 0, -1);
    expect_status("R9 overrun only", 10'h001);
    chk("R9 flag set", int'(ovr_flag), 1);
    buf_full = 1'b0;
    @(negedge clk);
    send_frame(64, 0, -1);
    chk("R10 dropped", int'(status_vld), 0);
    chk("R10 flag held", int'(ovr_flag), 1);
    @(negedge clk);
    send_frame(20, 0, -1);
    chk("R10 short dropped", int'(status_vld), 0);
    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk("R10 cleared", int'(ovr_flag), 0);
    send_frame(64, 0, -1);
    expect_status("R10 resume, R9 carrier kept", 10'h004);
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule